// File: doc/BRIEF.md
# Vector Any-Element-Equal Search Unit

This unit scans a 128-bit vector operand A and marks each of its elements that equals any element of a second 128-bit operand B, wherever that B element sits in the vector. Elements are 8, 16 or 32 bits wide, chosen by a size code per operation. Three flags shape the answer. Invert turns "equal to something in B" into "equal to nothing in B". Mask mode returns the per-element answer as a vector of all-ones and all-zeros elements instead of a position. Zero search also looks for the first all-zero element of A, which works as a string terminator.

In position mode, the upper doubleword of the result holds the byte offset of the earliest hit. Offsets count from the most significant byte. The lower doubleword is zero. A 2-bit condition code reports how hits and the terminator relate: no hit and no terminator, a hit with no terminator, a hit ahead of the terminator, or a terminator first. The unit sits next to a vector register file. A start strobe launches an operation, and the result comes back with a single-cycle done pulse. The result then holds until the next start.

Top module: `vec_anyeq_top`

## Requirements
- R1: An element of A counts as a hit when it equals any element of B at any position, not only the B element at the same position.
- R2: With mask mode off (flags bit 2 = 0), result bits 127:64 hold the byte offset of the first hit element, counted from the most significant byte (byte 0 = bits 127:120). The value is 16 when there is no hit. Result bits 63:0 are zero.
- R3: Size code 0 selects 8-bit elements, code 1 selects 16-bit elements and code 2 selects 32-bit elements. Bytes that straddle an element boundary never form a hit.
- R4: With flags bit 3 set, each element's hit indication is complemented before the offset or the mask is formed.
- R5: With flags bit 2 set, each result element is all ones when its A element is a hit, and all zeros otherwise.
- R6: With flags bit 1 set, A is also searched for its first all-zero element. In position mode the offset written is the smaller of the hit offset and the zero offset. With bit 1 clear, the zero offset is taken as 16.
- R7: The condition code is 3 when there is neither a hit nor a zero, 1 when there is a hit but no zero, 2 when the first hit precedes the first zero, and 0 otherwise.
- R8: A start sampled at a rising edge updates the result, the condition code and the error flag at that edge. Done is high for the following cycle only, and all outputs then hold until the next start.
- R9: Size code 3 is illegal. It sets sizeErr, forces the result to zero and sets the condition code to 0. The next legal start clears sizeErr.
- R10: After reset, result, condCode, done and sizeErr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Launch strobe; operands, size and flags are sampled with it |
| opA | input | 128 | Searched operand A |
| opB | input | 128 | Set-of-values operand B |
| sizeCode | input | 2 | Element size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = illegal |
| flags | input | 4 | Bit 3 invert, bit 2 mask mode, bit 1 zero search, bit 0 unused |
| result | output | 128 | Offset or element mask |
| condCode | output | 2 | Condition code |
| done | output | 1 | One-cycle pulse after each start |
| sizeErr | output | 1 | Set by an illegal size code, held until the next start |

## Verification
The assertions assume that the outputs change only at edges where startIn is high. They also assume that operand values reach the registers only through a start. The bench holds the operands, size and flags only for the single cycle that carries the strobe. It then keeps startIn low for stretches to expose holding behaviour.

The offset checks assume that the selected element size divides the vector evenly. The bench therefore sends size code 3 only as a deliberate error case. Random operands are built from a four-value byte alphabet, so that hits, misses and terminators all occur often.

// File: rtl/vec_anyeq_pkg.sv
`timescale 1ns/1ps
package vec_anyeq_pkg;
  localparam int VEC_BYTES = 16;
  localparam int NUM_SIZES = 3;
  localparam int FLAG_INV  = 3;
  localparam int FLAG_MASK = 2;
  localparam int FLAG_ZS   = 1;

  typedef struct packed {
    logic loadRes;
    logic loadErr;
  } ctrlStrobe_t;
endpackage

// File: rtl/vec_anyeq_ctrl.sv
`timescale 1ns/1ps
module vec_anyeq_ctrl
  import vec_anyeq_pkg::*;
#(
  parameter int SIZES = NUM_SIZES
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startIn,
  input  logic [1:0]  sizeCode,
  output ctrlStrobe_t strobe,
  output logic        doneOut,
  output logic        errOut
);
  logic sizeLegal;

  always_comb begin
    sizeLegal      = (int'(sizeCode) < SIZES);
    strobe.loadRes = startIn && sizeLegal;
    strobe.loadErr = startIn && !sizeLegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneOut <= 1'b0;
      errOut  <= 1'b0;
    end else begin
      doneOut <= startIn;
      if (startIn) errOut <= !sizeLegal;
    end
  end

  AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (doneOut && !$past(startIn, 2)) |-> !$past(doneOut)); // R8
endmodule

// File: rtl/vec_anyeq_dp.sv
`timescale 1ns/1ps
module vec_anyeq_dp
  import vec_anyeq_pkg::*;
#(
  parameter int NBYTES = VEC_BYTES,
  parameter int SIZES  = NUM_SIZES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrlStrobe_t           strobe,
  input  logic [NBYTES*8-1:0]   opA,
  input  logic [NBYTES*8-1:0]   opB,
  input  logic [1:0]            sizeCode,
  input  logic [3:0]            flags,
  output logic [NBYTES*8-1:0]   result,
  output logic [1:0]            condCode
);
  localparam int VW   = NBYTES * 8;
  localparam int HW   = VW / 2;
  localparam int IDXW = $clog2(NBYTES + 1);
  localparam logic [IDXW-1:0] NONE = IDXW'(NBYTES);

  // byte flags: bit NBYTES-1 is the most significant byte
  logic [SIZES-1:0][NBYTES-1:0] hitBytes;
  logic [SIZES-1:0][NBYTES-1:0] zeroBytes;

  for (genvar s = 0; s < SIZES; s++) begin : g_size
    localparam int EB = 1 << s;
    localparam int NE = NBYTES / EB;
    localparam int EW = EB * 8;
    for (genvar i = 0; i < NE; i++) begin : g_elem
      logic hit;
      logic [EW-1:0] elemA;
      always_comb begin
        elemA = opA[VW-1-i*EW -: EW];
        hit   = 1'b0;
        for (int j = 0; j < NE; j++) begin
          if (elemA == opB[VW-1-j*EW -: EW]) hit = 1'b1;
        end
      end
      assign hitBytes[s][NBYTES-1-i*EB -: EB]  = {EB{hit}};
      assign zeroBytes[s][NBYTES-1-i*EB -: EB] = {EB{elemA == '0}};
    end
  end

  function automatic logic [IDXW-1:0] firstSet(input logic [NBYTES-1:0] v);
    logic [IDXW-1:0] r;
    r = NONE;
    for (int k = 0; k < NBYTES; k++) begin
      if (v[k]) r = IDXW'(NBYTES - 1 - k);
    end
    return r;
  endfunction

  logic [NBYTES-1:0] selHit, selZero;
  logic [IDXW-1:0]   hitIdx, zeroIdx, minIdx;
  logic [VW-1:0]     maskVec, idxVec, nextRes;
  logic [1:0]        nextCc;
  logic              idxModeQ;

  always_comb begin
    selHit  = '0;
    selZero = '0;
    if (int'(sizeCode) < SIZES) begin
      selHit  = hitBytes[sizeCode];
      selZero = zeroBytes[sizeCode];
    end
    selHit  = selHit ^ {NBYTES{flags[FLAG_INV]}};
    hitIdx  = firstSet(selHit);
    zeroIdx = flags[FLAG_ZS] ? firstSet(selZero) : NONE;
    minIdx  = (hitIdx < zeroIdx) ? hitIdx : zeroIdx;
    for (int k = 0; k < NBYTES; k++) maskVec[k*8 +: 8] = {8{selHit[k]}};
    idxVec = '0;
    idxVec[HW +: IDXW] = minIdx;
    nextRes = flags[FLAG_MASK] ? maskVec : idxVec;
    if (zeroIdx == NONE && hitIdx == NONE) nextCc = 2'd3;
    else if (zeroIdx == NONE)              nextCc = 2'd1;
    else if (hitIdx < zeroIdx)             nextCc = 2'd2;
    else                                   nextCc = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      condCode <= 2'd0;
      idxModeQ <= 1'b0;
    end else if (strobe.loadRes) begin
      result   <= nextRes;
      condCode <= nextCc;
      idxModeQ <= !flags[FLAG_MASK];
    end else if (strobe.loadErr) begin
      result   <= '0;
      condCode <= 2'd0;
      idxModeQ <= 1'b0;
    end
  end

  AST_IDX_LOWER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    idxModeQ |-> (result[HW-1:0] == '0 && result[VW-1:HW] <= HW'(NBYTES))); // R2
  AST_CC3_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (idxModeQ && condCode == 2'd3) |-> result[VW-1:HW] == HW'(NBYTES)); // R7
  AST_CC2_HIT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (idxModeQ && condCode == 2'd2) |-> result[VW-1:HW] < HW'(NBYTES)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.loadRes && !strobe.loadErr) |=> $stable(result) && $stable(condCode)); // R8
  for (genvar k = 0; k < NBYTES; k++) begin : g_maskchk
    AST_MASK_WHOLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !idxModeQ |-> (result[k*8 +: 8] == 8'h00 || result[k*8 +: 8] == 8'hFF)); // R5
  end
endmodule

// File: rtl/vec_anyeq_top.sv
`timescale 1ns/1ps
module vec_anyeq_top
  import vec_anyeq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startIn,
  input  logic [127:0] opA,
  input  logic [127:0] opB,
  input  logic [1:0]   sizeCode,
  input  logic [3:0]   flags,
  output logic [127:0] result,
  output logic [1:0]   condCode,
  output logic         done,
  output logic         sizeErr
);
  ctrlStrobe_t strobe;

  vec_anyeq_ctrl #(.SIZES(NUM_SIZES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .sizeCode(sizeCode),
    .strobe(strobe), .doneOut(done), .errOut(sizeErr)
  );

  vec_anyeq_dp #(.NBYTES(VEC_BYTES), .SIZES(NUM_SIZES)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opA(opA), .opB(opB),
    .sizeCode(sizeCode), .flags(flags), .result(result), .condCode(condCode)
  );

  AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    sizeErr |-> (result == '0 && condCode == 2'd0)); // R9
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    startIn |=> done); // R8
endmodule

// File: tb/vec_anyeq_top_tb_top.sv
`timescale 1ns/1ps
module vec_anyeq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startIn = 1'b0;
  logic [127:0] opA = '0, opB = '0;
  logic [1:0] sizeCode = '0;
  logic [3:0] flags = '0;
  logic [127:0] result;
  logic [1:0] condCode;
  logic done, sizeErr;

  always #5 clk = ~clk;

  vec_anyeq_top dut_i (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .opA(opA), .opB(opB),
    .sizeCode(sizeCode), .flags(flags), .result(result),
    .condCode(condCode), .done(done), .sizeErr(sizeErr)
  );

  typedef struct {
    logic [127:0] res;
    logic [1:0]   cc;
    logic         err;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastExp;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  function automatic logic [7:0] byteAt(logic [127:0] v, int k);
    return v[127-8*k -: 8];
  endfunction

  function automatic expItem_t model(logic [127:0] a, logic [127:0] b,
                                     logic [1:0] sz, logic [3:0] fl, string tag);
    expItem_t e;
    int eb, ne, fh, fz, mn;
    e.tag = tag;
    e.res = '0;
    e.cc  = 2'd0;
    e.err = (sz == 2'd3);
    if (e.err) return e;
    eb = 1 << sz;
    ne = 16 / eb;
    fh = 16;
    fz = 16;
    for (int i = 0; i < ne; i++) begin
      bit hit = 0;
      bit isZero = 1;
      for (int j = 0; j < ne; j++) begin
        bit same = 1;
        for (int q = 0; q < eb; q++)
          if (byteAt(a, i*eb+q) != byteAt(b, j*eb+q)) same = 0;
        if (same) hit = 1;
      end
      for (int q = 0; q < eb; q++)
        if (byteAt(a, i*eb+q) != 8'h00) isZero = 0;
      if (fl[3]) hit = !hit;
      if (hit && fh == 16) fh = i*eb;
      if (fl[1] && isZero && fz == 16) fz = i*eb;
      if (fl[2] && hit)
        for (int q = 0; q < eb; q++) e.res[127-8*(i*eb+q) -: 8] = 8'hFF;
    end
    mn = (fh < fz) ? fh : fz;
    if (!fl[2]) e.res[127:64] = 64'(mn);
    if (fz == 16 && fh == 16) e.cc = 2'd3;
    else if (fz == 16)        e.cc = 2'd1;
    else if (fh < fz)         e.cc = 2'd2;
    else                      e.cc = 2'd0;
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what,
                       logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(logic [127:0] a, logic [127:0] b, logic [1:0] sz,
                       logic [3:0] fl, string tag);
    expItem_t e;
    e = model(a, b, sz, fl, tag);
    expQ.push_back(e);
    lastExp = e;
    opA = a; opB = b; sizeCode = sz; flags = fl; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    opA = '0; opB = '0; sizeCode = '0; flags = '0;
  endtask

  // monitor: pop and compare whenever done is seen
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (expQ.size() == 0) begin
        check(0, "R8", "unexpected done", 128'(done), 128'(0));
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(result == e.res && condCode == e.cc && sizeErr == e.err, e.tag,
              "result/cc/err", {result[127:3], condCode, sizeErr},
              {e.res[127:3], e.cc, e.err});
      end
    end
  end

  function automatic logic [127:0] ramp();
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[127-8*k -: 8] = 8'(16 + k);
    return v;
  endfunction

  function automatic logic [127:0] setB(logic [127:0] v, int k, logic [7:0] x);
    v[127-8*k -: 8] = x;
    return v;
  endfunction

  task automatic finish();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    check(0, "R8", "watchdog expired", '0, '0);
    finish();
  end

  initial begin
    logic [127:0] a, b, bNone;
    repeat (3) @(negedge clk);
    check(result == '0 && condCode == 0 && !done && !sizeErr, "R10", "reset state",
          {result[127:4], condCode, done, sizeErr}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    a = ramp();
    bNone = {16{8'hAA}};
    b = setB(bNone, 12, 8'h15);                       // A byte 5 at B byte 12
    runOp(a, b, 2'd0, 4'b0000, "R1");                 // offset 5, cc 1
    runOp(a, bNone, 2'd0, 4'b0000, "R7");             // no hit: 16, cc 3
    runOp(a, b, 2'd0, 4'b0100, "R5");                 // mask byte 5
    runOp(a, b, 2'd0, 4'b1000, "R4");                 // inverted: offset 0
    runOp(setB(a, 3, 8'h00), b, 2'd0, 4'b0010, "R6"); // zero first: 3, cc 0
    runOp(setB(a, 9, 8'h00), b, 2'd0, 4'b0010, "R7"); // hit first: 5, cc 2
    runOp(setB(a, 3, 8'h00), b, 2'd0, 4'b0000, "R6"); // zs off: 5, cc 1
    // halfwords: A elem 2 (bytes 4,5) placed at B elem 6; straddle 0x15,0x16 at bytes 1,2
    b = setB(setB(bNone, 12, 8'h14), 13, 8'h15);
    b = setB(setB(b, 1, 8'h15), 2, 8'h16);
    runOp(a, b, 2'd1, 4'b0000, "R3");
    runOp(a, setB(setB(bNone, 1, 8'h15), 2, 8'h16), 2'd1, 4'b0000, "R3");
    // words: A elem 3 (bytes 12..15) in B elem 0
    b = {a[31:0], bNone[95:0]};
    runOp(a, b, 2'd2, 4'b0100, "R3");
    runOp(a, b, 2'd2, 4'b0000, "R2");
    runOp(a, b, 2'd3, 4'b0100, "R9");
    // R8: hold with start low
    repeat (3) begin
      @(negedge clk);
      check(!done && sizeErr && result == '0, "R8", "hold after error",
            {result[127:2], done, sizeErr}, 128'd1);
    end
    runOp(a, b, 2'd2, 4'b0000, "R9");                 // legal start clears error
    repeat (2) begin
      @(negedge clk);
      check(!done && result == lastExp.res && condCode == lastExp.cc, "R8",
            "hold", result, lastExp.res);
    end
    // back-to-back starts
    runOp(a, bNone, 2'd0, 4'b0010, "R8");
    runOp(a, setB(bNone, 0, 8'h1F), 2'd0, 4'b0000, "R8");
    @(negedge clk);
    // random patterns from a small byte alphabet
    for (int n = 0; n < 60; n++) begin
      logic [127:0] ra, rb;
      for (int k = 0; k < 16; k++) begin
        ra[8*k +: 8] = 8'($urandom_range(0, 3));
        rb[8*k +: 8] = 8'($urandom_range(1, 4));
      end
      runOp(ra, rb, 2'($urandom_range(0, 2)), 4'($urandom_range(0, 15)), "R1");
      if (n % 4 == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8", "missing done", 128'(expQ.size()), '0);
    finish();
  end
endmodule